// File: doc/BRIEF.md
# Bid-Based Interrupt Arbiter with Vector

This block picks one interrupt source out of two serial channels and presents it to a host. Each channel delivers a vector of pending source flags, and a per-channel enable mask register, written by the host, gates them. Every source type has a programmable 8-bit bid. An eligible source competes with the arbitration key {bid, channel, source index}. Because the channel and index sit in the low bits, no two keys can be equal. One comparison spans both channels and picks the largest key.

The winning bid is compared with a programmable threshold to drive an active-low interrupt request. When the host acknowledges the interrupt, or issues an update command, the current winner is captured into a current-interrupt record. The record holds the channel, source type and bid. An 8-bit vector is captured with it, in one of four formats. The record stays frozen until the next acknowledge or update, while arbitration carries on underneath.

Top module: `irq_bid_arbiter`

## Requirements
- R1: A source takes part in arbitration only when its pending flag and its mask bit are both 1. A pending source whose mask bit is 0 never raises the request.
- R2: The arbitration key is {bid[7:0], channel, index[2:0]} and the largest key wins. With equal bids, channel B (code 1) beats channel A (code 0), and within a channel the higher index wins.
- R3: `irq_n` is registered. One clock after the inputs settle, it is 0 exactly when a winner exists and the winner's bid is strictly greater than `threshold`. Otherwise it is 1.
- R4: At a clock edge where `iack` or `upd_cmd` is 1, the current-interrupt record (`cir_valid`, `cir_chan`, `cir_type`, `cir_bid`) and `vector` take the current winner, visible after that edge. `cir_valid` is 1 only if the winner also passes the threshold test of R3. At all other edges the record and `vector` hold their values.
- R5: `vector` is captured with the record, using `vec_mode` and `vec_base` at that edge. If `cir_valid` would be 0, it is 0xFF. Otherwise: mode 00 gives 0xFF, mode 01 gives `vec_base`, mode 10 gives {vec_base[7:1], chan}, and mode 11 gives {vec_base[7:5], 0, type[2:0], chan}.
- R6: On reset both mask registers are 0x00, `irq_n` is 1, `cir_valid` is 0 and `vector` is 0xFF. `mask_wr[0]` loads `mask_wdata` into the channel A mask and `mask_wr[1]` into the channel B mask, taking effect at that edge.
- R7: `cir_chan` is 0 for channel A and 1 for channel B. `cir_type` is the winning source index, and `cir_bid` is its bid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sts_a | input | 8 | Pending source flags, channel A |
| sts_b | input | 8 | Pending source flags, channel B |
| mask_wr | input | 2 | Mask write strobes, bit 0 channel A, bit 1 channel B |
| mask_wdata | input | 8 | Mask write data |
| bid_cfg | input | 64 | Bid per source type, type i at bits [8i+7:8i] |
| threshold | input | 8 | Bid threshold for the request |
| vec_mode | input | 2 | Vector format select |
| vec_base | input | 8 | Base vector value |
| iack | input | 1 | Interrupt acknowledge, captures the winner |
| upd_cmd | input | 1 | Update command, captures the winner |
| irq_n | output | 1 | Active-low interrupt request |
| cir_valid | output | 1 | Captured record holds a qualifying interrupt |
| cir_chan | output | 1 | Captured channel code |
| cir_type | output | 3 | Captured source index |
| cir_bid | output | 8 | Captured bid |
| vector | output | 8 | Captured vector |

## Verification
Arbitration is combinational, and every output sits behind one register. `irq_n` therefore reflects inputs one edge after they are applied, and a mask write shows in `irq_n` one edge after the write edge. The record and `vector` change at the edge where `iack` or `upd_cmd` is sampled high. The bench drives all inputs on falling edges and samples every result on the falling edge that follows the edge where it is due. It also samples the record again after later edges without a capture, to confirm that the record holds.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef enum logic [1:0] {
    VEC_NONE  = 2'b00,
    VEC_PLAIN = 2'b01,
    VEC_CHAN  = 2'b10,
    VEC_FULL  = 2'b11
  } vec_mode_e;
endpackage

// File: rtl/irq_src_elig.sv
module irq_src_elig #(
  parameter int NUM_SRC = 8,
  parameter int BID_W   = 8,
  parameter bit CHAN    = 1'b0,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int KEY_W  = BID_W + 1 + SRC_W
) (
  input  logic [NUM_SRC-1:0]       sts,
  input  logic [NUM_SRC-1:0]       mask,
  input  logic [NUM_SRC*BID_W-1:0] bid_cfg,
  output logic [NUM_SRC-1:0]       elig,
  output logic [NUM_SRC*KEY_W-1:0] keys
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign elig[i] = sts[i] & mask[i];
    assign keys[i*KEY_W +: KEY_W] = {bid_cfg[i*BID_W +: BID_W], CHAN, SRC_W'(i)};
  end
endmodule

// File: rtl/irq_max_pick.sv
module irq_max_pick #(
  parameter int N     = 16,
  parameter int KEY_W = 12
) (
  input  logic [N-1:0]       vld,
  input  logic [N*KEY_W-1:0] keys,
  output logic               win_vld,
  output logic [KEY_W-1:0]   win_key
);
  always_comb begin
    win_vld = 1'b0;
    win_key = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && (!win_vld || keys[i*KEY_W +: KEY_W] > win_key)) begin
        win_vld = 1'b1;
        win_key = keys[i*KEY_W +: KEY_W];
      end
    end
  end
endmodule

// File: rtl/irq_bid_arbiter.sv
module irq_bid_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int BID_W   = 8,
  parameter int VEC_W   = 8,
  localparam int SRC_W  = $clog2(NUM_SRC),
  localparam int KEY_W  = BID_W + 1 + SRC_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC-1:0]       sts_a,
  input  logic [NUM_SRC-1:0]       sts_b,
  input  logic [1:0]               mask_wr,
  input  logic [NUM_SRC-1:0]       mask_wdata,
  input  logic [NUM_SRC*BID_W-1:0] bid_cfg,
  input  logic [BID_W-1:0]         threshold,
  input  logic [1:0]               vec_mode,
  input  logic [VEC_W-1:0]         vec_base,
  input  logic                     iack,
  input  logic                     upd_cmd,
  output logic                     irq_n,
  output logic                     cir_valid,
  output logic                     cir_chan,
  output logic [SRC_W-1:0]         cir_type,
  output logic [BID_W-1:0]         cir_bid,
  output logic [VEC_W-1:0]         vector
);
  import irq_arb_pkg::*;

  logic [NUM_SRC-1:0]         mask_a, mask_b;
  logic [2*NUM_SRC-1:0]       elig;
  logic [2*NUM_SRC*KEY_W-1:0] keys;
  logic                       win_vld;
  logic [KEY_W-1:0]           win_key;
  logic [BID_W-1:0]           win_bid;
  logic                       win_chan;
  logic [SRC_W-1:0]           win_idx;
  logic                       win_hit;
  logic                       capture;
  logic [VEC_W-1:0]           vec_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_a <= '0;
      mask_b <= '0;
    end else begin
      if (mask_wr[0]) mask_a <= mask_wdata;
      if (mask_wr[1]) mask_b <= mask_wdata;
    end
  end

  irq_src_elig #(.NUM_SRC(NUM_SRC), .BID_W(BID_W), .CHAN(1'b0)) u_elig_a (
    .sts(sts_a), .mask(mask_a), .bid_cfg(bid_cfg),
    .elig(elig[NUM_SRC-1:0]), .keys(keys[NUM_SRC*KEY_W-1:0]));

  irq_src_elig #(.NUM_SRC(NUM_SRC), .BID_W(BID_W), .CHAN(1'b1)) u_elig_b (
    .sts(sts_b), .mask(mask_b), .bid_cfg(bid_cfg),
    .elig(elig[2*NUM_SRC-1:NUM_SRC]), .keys(keys[2*NUM_SRC*KEY_W-1:NUM_SRC*KEY_W]));

  irq_max_pick #(.N(2*NUM_SRC), .KEY_W(KEY_W)) u_pick (
    .vld(elig), .keys(keys), .win_vld(win_vld), .win_key(win_key));

  assign win_bid  = win_key[KEY_W-1 -: BID_W];
  assign win_chan = win_key[SRC_W];
  assign win_idx  = win_key[SRC_W-1:0];
  assign win_hit  = win_vld && (win_bid > threshold);
  assign capture  = iack || upd_cmd;

  always_comb begin
    vec_next = '1;
    if (win_hit) begin
      case (vec_mode_e'(vec_mode))
        VEC_NONE:  vec_next = '1;
        VEC_PLAIN: vec_next = vec_base;
        VEC_CHAN:  vec_next = {vec_base[VEC_W-1:1], win_chan};
        VEC_FULL:  vec_next = {vec_base[VEC_W-1:VEC_W-3], 4'(win_idx), win_chan};
        default:   vec_next = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_n     <= 1'b1;
      cir_valid <= 1'b0;
      cir_chan  <= 1'b0;
      cir_type  <= '0;
      cir_bid   <= '0;
      vector    <= '1;
    end else begin
      irq_n <= !win_hit;
      if (capture) begin
        cir_valid <= win_hit;
        cir_chan  <= win_chan;
        cir_type  <= win_idx;
        cir_bid   <= win_bid;
        vector    <= vec_next;
      end
    end
  end

  assert_mask_reset_R6: assert property (@(posedge clk)
    $past(rst) |-> (mask_a == '0 && mask_b == '0));

  assert_irq_thresh_R3: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(win_vld && (win_bid > threshold)));

  assert_cir_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !capture |=> ($stable(cir_valid) && $stable(cir_bid) && $stable(cir_type)
                  && $stable(cir_chan) && $stable(vector)));

  assert_vec_none_R5: assert property (@(posedge clk) disable iff (rst)
    (capture && vec_mode == 2'b00) |=> (vector == '1));

  assert_masked_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (mask_a == '0 && mask_b == '0) |=> irq_n);
endmodule

// File: tb/irq_bid_arbiter_test.sv
module irq_bid_arbiter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  sts_a, sts_b, mask_wdata, threshold, vec_base;
  logic [1:0]  mask_wr, vec_mode;
  logic [63:0] bid_cfg;
  logic        iack, upd_cmd;
  logic        irq_n, cir_valid, cir_chan;
  logic [2:0]  cir_type;
  logic [7:0]  cir_bid, vector;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [7:0] m_a, m_b;

  always #10 clk = ~clk;

  irq_bid_arbiter uut (
    .clk(clk), .rst(rst), .sts_a(sts_a), .sts_b(sts_b), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .bid_cfg(bid_cfg), .threshold(threshold),
    .vec_mode(vec_mode), .vec_base(vec_base), .iack(iack), .upd_cmd(upd_cmd),
    .irq_n(irq_n), .cir_valid(cir_valid), .cir_chan(cir_chan),
    .cir_type(cir_type), .cir_bid(cir_bid), .vector(vector));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // returns {valid, bid[7:0], chan, idx[2:0]}
  function automatic logic [12:0] model();
    logic [12:0] best = '0;
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 8; i++) begin
        logic p = (c == 0) ? (sts_a[i] & m_a[i]) : (sts_b[i] & m_b[i]);
        logic [11:0] k = {bid_cfg[i*8 +: 8], c[0], i[2:0]};
        if (p && (!best[12] || k > best[11:0])) best = {1'b1, k};
      end
    end
    return best;
  endfunction

  function automatic logic exp_hit(logic [12:0] w);
    return w[12] && (w[11:4] > threshold);
  endfunction

  function automatic logic [7:0] exp_vec(logic [12:0] w);
    if (!exp_hit(w)) return 8'hFF;
    case (vec_mode)
      2'b00:   return 8'hFF;
      2'b01:   return vec_base;
      2'b10:   return {vec_base[7:1], w[3]};
      default: return {vec_base[7:5], 1'b0, w[2:0], w[3]};
    endcase
  endfunction

  task automatic set_masks(logic [7:0] ma, logic [7:0] mb);
    @(negedge clk); mask_wr = 2'b01; mask_wdata = ma;
    @(negedge clk); mask_wr = 2'b10; mask_wdata = mb;
    @(negedge clk); mask_wr = 2'b00;
    m_a = ma; m_b = mb;
  endtask

  task automatic apply(logic [7:0] sa, logic [7:0] sb, logic [63:0] bids,
                       logic [7:0] thr, string tag);
    logic [12:0] w;
    sts_a = sa; sts_b = sb; bid_cfg = bids; threshold = thr;
    w = model();
    @(negedge clk);
    check({tag, " irq_n R3"}, irq_n, !exp_hit(w));
  endtask

  task automatic capture(bit use_upd, string tag);
    logic [12:0] w;
    logic [7:0]  ev;
    logic        eh;
    w = model(); ev = exp_vec(w); eh = exp_hit(w);
    if (use_upd) upd_cmd = 1'b1; else iack = 1'b1;
    @(negedge clk);
    iack = 1'b0; upd_cmd = 1'b0;
    check({tag, " cir_valid R4"}, cir_valid, eh);
    if (eh) begin
      check({tag, " cir_bid R7"}, cir_bid, w[11:4]);
      check({tag, " cir_chan R7"}, cir_chan, w[3]);
      check({tag, " cir_type R2"}, cir_type, w[2:0]);
    end
    check({tag, " vector R5"}, vector, ev);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] sv_bid, sv_vec;
    logic [2:0] sv_type;
    logic       sv_chan;
    void'($urandom(32'd1234));
    rst = 1'b1; sts_a = '0; sts_b = '0; mask_wr = '0; mask_wdata = '0;
    threshold = '0; vec_mode = 2'b01; vec_base = 8'hA0; bid_cfg = '0;
    iack = 0; upd_cmd = 0; m_a = '0; m_b = '0;
    repeat (3) @(negedge clk);
    check("reset irq_n R6", irq_n, 1'b1);
    check("reset cir_valid R6", cir_valid, 1'b0);
    check("reset vector R6", vector, 8'hFF);
    rst = 1'b0;

    // R1/R6: masks are zero after reset, so pending sources stay quiet
    apply(8'hFF, 8'hFF, {8{8'hF0}}, 8'h00, "masked after reset R1 R6");
    capture(1'b0, "masked capture R1");

    // R1: pending but masked source ignored; lower unmasked one wins
    set_masks(8'h01, 8'h00);
    apply(8'h81, 8'h80, {8'hFF, {6{8'h00}}, 8'h10}, 8'h05, "mask gate R1");
    capture(1'b0, "mask gate R1");
    check("mask gate winner R1", cir_type, 3'd0);

    // R3: bid equal to threshold does not raise; one above does
    apply(8'h01, 8'h00, {{7{8'h00}}, 8'h40}, 8'h40, "bid eq thr R3");
    apply(8'h01, 8'h00, {{7{8'h00}}, 8'h41}, 8'h40, "bid above thr R3");

    // R2: equal bids, channel B beats A; within channel higher index wins
    set_masks(8'h24, 8'h24);
    apply(8'h24, 8'h24, {{2{8'h00}}, 8'h55, {2{8'h00}}, 8'h55, {2{8'h00}}}, 8'h00, "tie R2");
    capture(1'b1, "tie upd R2");
    check("tie chan B R2", cir_chan, 1'b1);
    check("tie index R2", cir_type, 3'd5);

    // R4: record holds while arbitration changes underneath
    vec_mode = 2'b11; vec_base = 8'hE0;
    capture(1'b0, "full vector R5");
    sv_bid = cir_bid; sv_type = cir_type; sv_chan = cir_chan; sv_vec = vector;
    apply(8'h00, 8'h04, {8{8'h99}}, 8'h00, "changed inputs R4");
    @(negedge clk);
    check("hold bid R4", cir_bid, sv_bid);
    check("hold type R4", cir_type, sv_type);
    check("hold chan R4", cir_chan, sv_chan);
    check("hold vector R4", vector, sv_vec);

    // R5: each vector mode
    for (int md = 0; md < 4; md++) begin
      vec_mode = md[1:0]; vec_base = 8'h5A;
      capture(md[0], "mode sweep R5");
    end

    // random mix
    for (int it = 0; it < 300; it++) begin
      if (it % 4 == 0) set_masks($urandom, $urandom);
      vec_mode = $urandom; vec_base = $urandom;
      apply($urandom, $urandom, {$urandom, $urandom}, $urandom % 200, "random R1 R3");
      capture($urandom % 2, "random R2 R7");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule